// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides whether a received Ethernet frame is kept. It watches the destination address as it arrives from the receive path, one byte per accepted strobe. After the sixth address byte it raises a decision flag together with an accept/reject verdict. The receive logic downstream uses the verdict to keep or drop the rest of the frame.

A frame passes when any of these is true:
- the destination is the all-ones broadcast address;
- the destination equals the programmed station address;
- the destination is a group address and the accept-every-group control is set;
- the destination is a group address whose hash selects a set bit of the 64-bit group table.

The promiscuous control overrides all of these and keeps every frame. A one-cycle frame-start pulse clears the filter before each new frame.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: After reset, `decision_valid` and `accept` are 0 until a full six-byte address has been taken.
- R2: Address bytes are taken on cycles with `byte_valid` high and `frame_start` low. The first byte taken is the least significant byte of the address.
- R3: An address of all ones (48 bits set) yields `accept`=1.
- R4: An address equal to `station_addr` yields `accept`=1. `station_addr[7:0]` is compared with the first byte taken, and each later byte is compared with the next higher eight bits.
- R5: An address counts as group (multicast) when bit 0 of its first byte is 1. Any group address yields `accept`=1 while `all_mcast_en` is 1.
- R6: Group hash: a CRC-32 register starts at all ones. For every address bit, bit 0 of the first byte first, it is shifted right one place and XORed with 0xEDB88320 whenever the outgoing bit XOR the data bit is 1. The low six bits of the final register index `mcast_hash`. A group address whose indexed bit is 1 yields `accept`=1.
- R7: While `promisc_en` is 1, every address yields `accept`=1. The mode inputs are sampled on the edge that registers the decision.
- R8: An address that meets none of the conditions in R3 to R7 yields `accept`=0.
- R9: `decision_valid` rises on the clock edge after the edge that takes the sixth byte. It then stays high, with `accept` unchanged, until `frame_start`.
- R10: Bytes after the sixth are ignored until the next `frame_start`.
- R11: `frame_start` clears `decision_valid` and `accept` at the next edge and restarts address collection. A byte presented in the same cycle as `frame_start` is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse before each frame |
| byte_valid | input | 1 | Address byte strobe |
| byte_data | input | 8 | Address byte, least significant first |
| station_addr | input | 48 | Programmed individual address |
| mcast_hash | input | 64 | Group hash table |
| promisc_en | input | 1 | Keep every frame |
| all_mcast_en | input | 1 | Keep every group address |
| decision_valid | output | 1 | Verdict available |
| accept | output | 1 | 1 = keep frame, 0 = drop |

## Verification
Each internal fault shows up on the verdict of the frame it corrupts. A miscounted byte index or a stale match flag gives a wrong `accept` at the first `decision_valid` rise. A broken CRC step misroutes the hash lookup. This is visible on group addresses with a sparse table, one cycle after the sixth byte. Faults in restart or in ignoring extra bytes appear as a premature or missing `decision_valid`, or as an `accept` that changes while it should be held. The bench checks the flag on the cycle before the decision and on the cycle of the decision.

// File: rtl/eth_rx_filt_pkg.sv
package eth_rx_filt_pkg;
    localparam int unsigned OCTET_W     = 8;
    localparam int unsigned DA_OCTETS   = 6;
    localparam int unsigned HASH_BITS   = 64;
    localparam int unsigned HASH_IDX_W  = $clog2(HASH_BITS);
    localparam int unsigned FCS_W       = 32;
    localparam logic [FCS_W-1:0] FCS_POLY_REFL = 32'hEDB88320;
    localparam logic [FCS_W-1:0] FCS_SEED      = '1;

    typedef struct packed {
        logic station_eq;
        logic all_ones;
        logic group_bit;
    } octet_flags_t;
endpackage

// File: rtl/fcs_octet_step.sv
module fcs_octet_step #(
    parameter int unsigned CRC_W  = 32,
    parameter int unsigned DATA_W = 8,
    parameter logic [CRC_W-1:0] POLY = 32'hEDB88320
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);
    logic [CRC_W-1:0] stage [DATA_W+1];

    assign stage[0] = crc_in;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        logic fb;
        assign fb = stage[b][0] ^ data_in[b];
        assign stage[b+1] = (stage[b] >> 1) ^ (fb ? POLY : '0);
    end

    assign crc_out = stage[DATA_W];
endmodule

// File: rtl/da_octet_check.sv
module da_octet_check
    import eth_rx_filt_pkg::*;
#(
    parameter int unsigned N_OCTETS = 6,
    parameter int unsigned O_W      = 8,
    parameter int unsigned IDX_W    = $clog2(N_OCTETS + 1)
) (
    input  logic [O_W-1:0]          octet,
    input  logic [IDX_W-1:0]        idx,
    input  logic [N_OCTETS*O_W-1:0] station_addr,
    output octet_flags_t            flags
);
    logic [O_W-1:0] station_sel;

    always_comb begin
        station_sel = '0;
        for (int i = 0; i < N_OCTETS; i++) begin
            if (idx == IDX_W'(i)) station_sel = station_addr[i*O_W +: O_W];
        end
    end

    assign flags.station_eq = (octet == station_sel);
    assign flags.all_ones   = &octet;
    assign flags.group_bit  = octet[0];
endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
    import eth_rx_filt_pkg::*;
#(
    parameter int unsigned N_OCTETS = DA_OCTETS,
    parameter int unsigned O_W      = OCTET_W,
    parameter int unsigned TBL_BITS = HASH_BITS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_start,
    input  logic                    byte_valid,
    input  logic [O_W-1:0]          byte_data,
    input  logic [N_OCTETS*O_W-1:0] station_addr,
    input  logic [TBL_BITS-1:0]     mcast_hash,
    input  logic                    promisc_en,
    input  logic                    all_mcast_en,
    output logic                    decision_valid,
    output logic                    accept
);
    localparam int unsigned CNT_W = $clog2(N_OCTETS + 1);
    localparam int unsigned TIX_W = $clog2(TBL_BITS);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(N_OCTETS - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(N_OCTETS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [FCS_W-1:0] crc;
        logic             ind_ok;
        logic             bc_ok;
        logic             grp;
        logic             eval;
        logic             dvalid;
        logic             acc;
    } filt_state_t;

    filt_state_t st_d, st_q;
    logic [FCS_W-1:0] crc_next;
    octet_flags_t     oflags;
    logic             take;
    logic [TIX_W-1:0] tix;
    logic             verdict;

    fcs_octet_step #(
        .CRC_W (FCS_W),
        .DATA_W(O_W),
        .POLY  (FCS_POLY_REFL)
    ) crc_i (
        .crc_in (st_q.crc),
        .data_in(byte_data),
        .crc_out(crc_next)
    );

    da_octet_check #(
        .N_OCTETS(N_OCTETS),
        .O_W     (O_W),
        .IDX_W   (CNT_W)
    ) chk_i (
        .octet       (byte_data),
        .idx         (st_q.cnt),
        .station_addr(station_addr),
        .flags       (oflags)
    );

    assign take = byte_valid && !frame_start && (st_q.cnt < FULL_CNT);
    assign tix  = st_q.crc[TIX_W-1:0];

    always_comb begin
        verdict = promisc_en || st_q.bc_ok || st_q.ind_ok ||
                  (st_q.grp && (all_mcast_en || mcast_hash[tix]));

        st_d      = st_q;
        st_d.eval = 1'b0;
        if (take) begin
            st_d.cnt    = st_q.cnt + 1'b1;
            st_d.crc    = crc_next;
            st_d.ind_ok = st_q.ind_ok & oflags.station_eq;
            st_d.bc_ok  = st_q.bc_ok & oflags.all_ones;
            if (st_q.cnt == '0) st_d.grp = oflags.group_bit;
            st_d.eval   = (st_q.cnt == LAST_IDX);
        end
        if (st_q.eval) begin
            st_d.dvalid = 1'b1;
            st_d.acc    = verdict;
        end
        if (frame_start) begin
            st_d.cnt    = '0;
            st_d.crc    = FCS_SEED;
            st_d.ind_ok = 1'b1;
            st_d.bc_ok  = 1'b1;
            st_d.grp    = 1'b0;
            st_d.eval   = 1'b0;
            st_d.dvalid = 1'b0;
            st_d.acc    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt    <= '0;
            st_q.crc    <= FCS_SEED;
            st_q.ind_ok <= 1'b1;
            st_q.bc_ok  <= 1'b1;
            st_q.grp    <= 1'b0;
            st_q.eval   <= 1'b0;
            st_q.dvalid <= 1'b0;
            st_q.acc    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign decision_valid = st_q.dvalid;
    assign accept         = st_q.acc;

    // R10: the byte counter never passes the address length
    a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT);

    // R9: a verdict, once given, is held until the next frame start
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        decision_valid && !frame_start |=> decision_valid && $stable(accept));

    // R11: a frame start withdraws the verdict
    a_r11_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !decision_valid && !accept);

    // R3: a broadcast destination is kept
    a_r3_bcast: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(decision_valid) && $past(st_q.bc_ok) |-> accept);

    // R4: a station address match is kept
    a_r4_station: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(decision_valid) && $past(st_q.ind_ok) |-> accept);

    // R5: group address with accept-every-group set is kept
    a_r5_all_grp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(decision_valid) && $past(st_q.grp && all_mcast_en) |-> accept);

    // R7: promiscuous mode keeps everything
    a_r7_promisc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(decision_valid) && $past(promisc_en) |-> accept);
endmodule

// File: tb/eth_rx_addr_filter_tb.sv
module eth_rx_addr_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic [47:0] station_addr = 48'h0;
    logic [63:0] mcast_hash = 64'h0;
    logic        promisc_en = 1'b0;
    logic        all_mcast_en = 1'b0;
    logic        decision_valid;
    logic        accept;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    eth_rx_addr_filter dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start   (frame_start),
        .byte_valid    (byte_valid),
        .byte_data     (byte_data),
        .station_addr  (station_addr),
        .mcast_hash    (mcast_hash),
        .promisc_en    (promisc_en),
        .all_mcast_en  (all_mcast_en),
        .decision_valid(decision_valid),
        .accept        (accept)
    );

    function automatic logic [31:0] ref_crc(logic [47:0] a);
        logic [31:0] r = 32'hFFFFFFFF;
        for (int k = 0; k < 48; k++) begin
            logic fb;
            fb = r[0] ^ a[k];
            r  = r >> 1;
            if (fb) r = r ^ 32'hEDB88320;
        end
        return r;
    endfunction

    function automatic logic ref_accept(logic [47:0] a);
        logic grp;
        grp = a[0];
        if (promisc_en) return 1'b1;
        if (a == 48'hFFFF_FFFF_FFFF) return 1'b1;
        if (a == station_addr) return 1'b1;
        if (grp && all_mcast_en) return 1'b1;
        if (grp && mcast_hash[ref_crc(a)[5:0]]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pulse_start(input bit with_byte, input logic [7:0] b);
        @(negedge clk);
        frame_start = 1'b1;
        byte_valid  = with_byte;
        byte_data   = b;
        @(negedge clk);
        frame_start = 1'b0;
        byte_valid  = 1'b0;
    endtask

    task automatic push_byte(input logic [7:0] b, input int gap);
        for (int g = 0; g < gap; g++) @(negedge clk);
        byte_valid = 1'b1;
        byte_data  = b;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    // sends a full address and checks timing (R9) plus verdict
    task automatic run_addr(input logic [47:0] a, input bit gaps, input string req);
        logic exp;
        for (int j = 0; j < 6; j++) push_byte(a[j*8 +: 8], gaps ? int'($urandom_range(0, 2)) : 0);
        chk(decision_valid == 1'b0, "R9 early", {1'b0, decision_valid}, 2'd0);
        exp = ref_accept(a);
        @(negedge clk);
        chk(decision_valid == 1'b1, "R9 valid", {1'b0, decision_valid}, 2'd1);
        chk(accept == exp, req, {1'b0, accept}, {1'b0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [47:0] a;
        logic [63:0] hsparse;
        void'($urandom(32'h5eed_1234));
        station_addr = 48'h5544_3322_1100 ^ 48'h0000_0000_00a2;
        repeat (3) @(negedge clk);
        chk(decision_valid == 1'b0 && accept == 1'b0, "R1 reset", {decision_valid, accept}, 2'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(decision_valid == 1'b0, "R1 idle", {1'b0, decision_valid}, 2'd0);

        // R3 broadcast
        pulse_start(1'b0, 8'h00);
        run_addr(48'hFFFF_FFFF_FFFF, 1'b0, "R3 broadcast");
        // R4 station match, and byte order per R2
        pulse_start(1'b0, 8'h00);
        run_addr(station_addr, 1'b1, "R4 station");
        pulse_start(1'b0, 8'h00);
        run_addr({station_addr[7:0], station_addr[47:8]}, 1'b0, "R2 byte order");
        // R8 plain unicast miss
        pulse_start(1'b0, 8'h00);
        run_addr(station_addr ^ 48'h0100_0000_0000, 1'b0, "R8 near miss");
        // R5 group with all-multicast
        all_mcast_en = 1'b1;
        pulse_start(1'b0, 8'h00);
        run_addr(48'h1234_5678_9A01, 1'b0, "R5 all group");
        all_mcast_en = 1'b0;
        pulse_start(1'b0, 8'h00);
        run_addr(48'h1234_5678_9A01, 1'b0, "R8 group no table");
        // R6 single table bit at the hash index
        a = 48'h00AB_CDEF_5E01;
        mcast_hash = 64'h1 << ref_crc(a)[5:0];
        pulse_start(1'b0, 8'h00);
        run_addr(a, 1'b0, "R6 hash hit");
        mcast_hash = ~(64'h1 << ref_crc(a)[5:0]);
        pulse_start(1'b0, 8'h00);
        run_addr(a, 1'b0, "R6 hash miss");
        mcast_hash = 64'h0;
        // R7 promiscuous
        promisc_en = 1'b1;
        pulse_start(1'b0, 8'h00);
        run_addr(48'h1111_2222_3330, 1'b0, "R7 promisc");
        promisc_en = 1'b0;

        // R10 extra bytes after the sixth
        pulse_start(1'b0, 8'h00);
        run_addr(station_addr, 1'b0, "R4 station again");
        for (int j = 0; j < 4; j++) push_byte(8'h5A, 0);
        @(negedge clk);
        chk(decision_valid == 1'b1 && accept == 1'b1, "R10 extra ignored", {decision_valid, accept}, 2'd3);

        // R11 start clears, then restart mid-address
        pulse_start(1'b0, 8'h00);
        chk(decision_valid == 1'b0 && accept == 1'b0, "R11 cleared", {decision_valid, accept}, 2'd0);
        push_byte(8'hFF, 0);
        push_byte(8'hFF, 0);
        pulse_start(1'b0, 8'h00);
        run_addr(station_addr, 1'b0, "R11 restart");
        // R11 byte with frame_start not taken
        pulse_start(1'b1, 8'hFF);
        run_addr(station_addr, 1'b0, "R11 start byte dropped");

        // random mix
        for (int n = 0; n < 300; n++) begin
            int kind;
            kind = int'($urandom_range(0, 4));
            a = {$urandom, $urandom};
            case (kind)
                1: a = 48'hFFFF_FFFF_FFFF;
                2: a = station_addr;
                3: a[0] = 1'b1;
                4: a = station_addr ^ (48'h1 << $urandom_range(1, 47));
                default: ;
            endcase
            promisc_en   = ($urandom_range(0, 7) == 0);
            all_mcast_en = ($urandom_range(0, 3) == 0);
            hsparse = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            mcast_hash = hsparse;
            pulse_start(1'b0, 8'h00);
            run_addr(a, 1'b1, "R8 random");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule